// File: doc/BRIEF.md
# Dual-Event Performance Counter Unit

This block sits beside a processor pipeline and counts hardware events on two independent 32-bit counters, called slot 0 and slot 1. A control register picks one event code for each slot and sets which privilege levels may count. Every cycle the block samples a vector of event lines coming from the pipeline and caches. A line may be a one-cycle strobe, such as a completed instruction or a cache reference. It may also be a level that stays high for the whole of a stall. In both cases the selected slot adds one on each rising clock edge where its line is high and counting is permitted.

Software reads and writes the control register and both counters through a small synchronous register port. Ratios such as cycles per instruction or cache hit rate are computed outside the block from pairs of counts. Each slot has its own set of event codes. Cycle and completed-instruction counting work on both slots. Reference events exist only on slot 0, and the matching hit events exist only on slot 1, so that one measurement gives a reference count and a hit count at the same time.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset the control register reads 0x101: user counting on, supervisor counting off, slot 0 on code 0 (cycles) and slot 1 on code 1 (completed instructions). Both counters read 0 and both overflow flags are 0.
- R2: The control register sits at address 0. Bit 0 is the user enable, bit 1 the supervisor enable, bits 7:4 the slot 0 code and bits 11:8 the slot 1 code. A write stores bits 11:0, and a read returns them with bits 31:12 equal to zero. Slot 0 is at address 1 and slot 1 at address 2.
- R3: A slot may count in a cycle only if one of two conditions holds. Either priv_sup is 0 and the user enable is set, or priv_sup is 1 and the supervisor enable is set.
- R4: Code 0 adds one on every clock edge where counting is permitted, on either slot.
- R5: Any other supported code adds exactly one per clock edge on which ev_in[code] is high. This includes a level held high for several cycles. Slot 0 accepts codes 0, 1, 2, 4, 6 and 8. Slot 1 accepts codes 0, 1, 3, 5, 7 and 9.
- R6: When a slot selects a code it does not accept (for example 3 on slot 0, 2 on slot 1, or 10 to 15 on either slot), that slot never changes from counting.
- R7: A register-port write to a counter replaces its value and takes priority over an increment in the same cycle. A read returns the current value, before any increment at the next edge.
- R8: A counter wraps from 0xFFFFFFFF to 0. On that wrap its overflow flag (pic_ovf bit 0 for slot 0, bit 1 for slot 1) sets and stays set, until any write to the control register clears both flags.
- R9: The two slots count at the same time and independently of each other. An event on one slot never changes the other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all events are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_sup | input | 1 | Current privilege: 1 = supervisor, 0 = user |
| ev_in | input | 16 | Event lines indexed by event code; bit 0 is unused because code 0 counts cycles |
| reg_addr | input | 2 | Register select: 0 control, 1 slot 0, 2 slot 1 |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| pic_ovf | output | 2 | Sticky wrap flags, one per slot |

## Verification
The bench goes after the privilege gate from both sides. A gate that ignored the mode would count supervisor cycles under the reset setup, and one with the enables swapped would count only the wrong mode. It selects codes a slot does not accept while every event line is high; a design that decoded all codes on both slots would count there. It crosses the 0xFFFFFFFF boundary and then counts past it, which exposes a missing or non-sticky flag and a flag that a control write fails to clear. It also writes a counter in a cycle where it would have counted, where an adder taking priority over the write would leave the written value plus one.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   // Event code width and the number of codes it can name.
   localparam int unsigned SEL_W     = 4;
   localparam int unsigned NUM_CODES = 2 ** SEL_W;

   // Control register width. The field order matters to software.
   localparam int unsigned CTRL_W    = 12;

   // Register port addresses.
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_PIC0 = 2'd1,
      REG_PIC1 = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   // Event codes. Which slot accepts which code is set by the top parameters.
   typedef enum logic [SEL_W-1:0] {
      EV_CYCLES      = 4'd0,
      EV_INSTR_DONE  = 4'd1,
      EV_IFETCH_REF  = 4'd2,
      EV_IFETCH_HIT  = 4'd3,
      EV_L2_REF      = 4'd4,
      EV_L2_HIT      = 4'd5,
      EV_LOAD_STALL  = 4'd6,
      EV_FPU_STALL   = 4'd7,
      EV_IBUF_DRY_IC = 4'd8,
      EV_IBUF_DRY_BR = 4'd9
   } ev_code_e;

   // Control register layout, most significant field first.
   typedef struct packed {
      logic [SEL_W-1:0] sel1;   // 11:8
      logic [SEL_W-1:0] sel0;   // 7:4
      logic [1:0]       spare;  // 3:2, stored, no effect
      logic             sup_en; // 1
      logic             usr_en; // 0
   } ctrl_t;

endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
   import pmc_pkg::*;
#(
   parameter logic [CTRL_W-1:0] RESET_CTRL = 12'h101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wdata,
   output ctrl_t             ctrl
);

   ctrl_t ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= ctrl_t'(RESET_CTRL);
      else if (wr_en) ctrl_q <= ctrl_t'(wdata);
   end

   assign ctrl = ctrl_q;

   // R2: a write is visible in full on the next cycle
   a_r2_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ctrl == ctrl_t'($past(wdata))));

   // R2: without a write the configuration holds
   a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ctrl));

endmodule

// File: rtl/pmc_event_select.sv
module pmc_event_select
   import pmc_pkg::*;
#(
   parameter logic [NUM_CODES-1:0] ACCEPT = '1
) (
   input  logic [SEL_W-1:0]     sel,
   input  logic [NUM_CODES-1:0] ev_in,
   input  logic                 gate_open,
   output logic                 hit
);

   logic raw;
   logic accepted;

   // Code 0 is the free-running cycle event; other codes read their own line.
   always_comb begin
      if (sel == SEL_W'(EV_CYCLES)) raw = 1'b1;
      else                          raw = ev_in[sel];
   end

   assign accepted = ACCEPT[sel];
   assign hit      = raw & accepted & gate_open;

endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);

   localparam logic [CNT_W-1:0] TOP = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic             wrap;

   assign wrap = inc & ~wr_en & (cnt_q == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (wr_en) cnt_q <= wr_data;
      else if (inc)   cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_q <= 1'b0;
      else if (ovf_clr) ovf_q <= 1'b0;
      else if (wrap)    ovf_q <= 1'b1;
   end

   assign cnt = cnt_q;
   assign ovf = ovf_q;

   // R7: software write beats increment
   a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cnt == $past(wr_data)));

   // R5: one step per qualified edge
   a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr_en) |=> (cnt == $past(cnt) + 1'b1));

   // R3: no increment, no write, no change
   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !wr_en) |=> $stable(cnt));

   // R8: wrap to zero sets the flag
   a_r8_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr_en && !ovf_clr && (cnt == TOP)) |=> (ovf && (cnt == '0)));

   // R8: flag is sticky until cleared
   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf);

   // R8: clear always wins
   a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_clr |=> !ovf);

endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
   import pmc_pkg::*;
#(
   parameter int unsigned           CNT_W       = 32,
   parameter logic [NUM_CODES-1:0]  SLOT0_CODES = 16'h0157,
   parameter logic [NUM_CODES-1:0]  SLOT1_CODES = 16'h02AB,
   parameter logic [CTRL_W-1:0]     RESET_CTRL  = 12'h101
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 priv_sup,
   input  logic [NUM_CODES-1:0] ev_in,
   input  logic [1:0]           reg_addr,
   input  logic                 reg_wr,
   input  logic [CNT_W-1:0]     reg_wdata,
   output logic [CNT_W-1:0]     reg_rdata,
   output logic [1:0]           pic_ovf
);

   localparam int unsigned NUM_SLOTS = 2;

   // Elaboration-time parameter checks
   if (CNT_W < CTRL_W) begin : g_bad_width
      $error("perf_counter_unit: CNT_W must hold the control register");
   end
   if (!SLOT0_CODES[0] || !SLOT1_CODES[0]) begin : g_bad_codes
      $error("perf_counter_unit: cycle code must be accepted by both slots");
   end

   ctrl_t            ctrl;
   logic             ctrl_wr;
   logic             gate_open;
   logic [CNT_W-1:0] pic_q   [NUM_SLOTS];
   logic [SEL_W-1:0] sel_a   [NUM_SLOTS];
   logic             hit_a   [NUM_SLOTS];
   logic             wr_a    [NUM_SLOTS];

   assign ctrl_wr = reg_wr & (reg_addr == REG_CTRL);

   pmc_ctrl_reg #(
      .RESET_CTRL (RESET_CTRL)
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (ctrl_wr),
      .wdata (reg_wdata[CTRL_W-1:0]),
      .ctrl  (ctrl)
   );

   // Privilege gate shared by both slots
   assign gate_open = (ctrl.usr_en & ~priv_sup) | (ctrl.sup_en & priv_sup);

   assign sel_a[0] = ctrl.sel0;
   assign sel_a[1] = ctrl.sel1;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam logic [NUM_CODES-1:0] ACC  = (s == 0) ? SLOT0_CODES : SLOT1_CODES;
      localparam logic [1:0]           ADDR = (s == 0) ? REG_PIC0 : REG_PIC1;

      assign wr_a[s] = reg_wr & (reg_addr == ADDR);

      pmc_event_select #(
         .ACCEPT (ACC)
      ) u_sel (
         .sel       (sel_a[s]),
         .ev_in     (ev_in),
         .gate_open (gate_open),
         .hit       (hit_a[s])
      );

      pmc_counter #(
         .CNT_W (CNT_W)
      ) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .inc     (hit_a[s]),
         .wr_en   (wr_a[s]),
         .wr_data (reg_wdata),
         .ovf_clr (ctrl_wr),
         .cnt     (pic_q[s]),
         .ovf     (pic_ovf[s])
      );

      // R6: a code this slot does not accept leaves it untouched
      a_r6_foreign_code: assert property (@(posedge clk) disable iff (!rst_n)
         (!ACC[sel_a[s]] && !wr_a[s]) |=> $stable(pic_q[s]));
   end

   // Register read mux
   always_comb begin
      unique case (reg_addr)
         REG_CTRL: reg_rdata = CNT_W'(ctrl);
         REG_PIC0: reg_rdata = pic_q[0];
         REG_PIC1: reg_rdata = pic_q[1];
         default:  reg_rdata = '0;
      endcase
   end

   // R3: a closed gate freezes both slots unless software writes
   a_r3_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_open && !reg_wr) |=> ($stable(pic_q[0]) && $stable(pic_q[1])));

   // R4: cycle code counts every permitted edge on slot 0
   a_r4_cycle_slot0: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_open && (ctrl.sel0 == SEL_W'(EV_CYCLES)) && !wr_a[0])
         |=> (pic_q[0] == $past(pic_q[0]) + 1'b1));

   // R9: writing one slot does not disturb the other when it is idle
   a_r9_slot_isolation: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_a[0] && !hit_a[1] && !wr_a[1]) |=> $stable(pic_q[1]));

endmodule

// File: tb/tb_perf_counter_unit.sv
module tb_perf_counter_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        priv_sup;
   logic [15:0] ev_in;
   logic [1:0]  reg_addr;
   logic        reg_wr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic [1:0]  pic_ovf;

   always #5 clk = ~clk;

   perf_counter_unit dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .priv_sup  (priv_sup),
      .ev_in     (ev_in),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pic_ovf   (pic_ovf)
   );

   // kind 0..2: register address; kind 3: overflow flags
   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t exp_q[$];
   event  chk_ev;
   int    n_cmp = 0;
   int    n_bad = 0;
   logic  idle_sup;
   bit    done = 1'b0;

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // Monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         @(chk_ev);
         #1;
         while (exp_q.size() > 0) begin
            item_t       it;
            logic [31:0] act;
            it  = exp_q.pop_front();
            act = (it.kind == 3) ? {30'b0, pic_ovf} : reg_rdata;
            n_cmp++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   // Driver side
   task automatic push_check(input int kind, input logic [31:0] exp, input string tag);
      item_t it;
      if (kind < 3) reg_addr = kind[1:0];
      it.kind = kind;
      it.exp  = exp;
      it.tag  = tag;
      exp_q.push_back(it);
      -> chk_ev;
      #2;
   endtask

   task automatic check_at(input int kind, input logic [31:0] exp, input string tag);
      @(negedge clk);
      push_check(kind, exp, tag);
   endtask

   task automatic wr(input logic [1:0] addr, input logic [31:0] data);
      @(negedge clk);
      reg_addr  = addr;
      reg_wdata = data;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
      priv_sup  = idle_sup;
   endtask

   task automatic run_ev(input logic [15:0] ev, input logic sup, input int n);
      @(negedge clk);
      ev_in    = ev;
      priv_sup = sup;
      repeat (n) @(negedge clk);
      ev_in    = '0;
      priv_sup = idle_sup;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
      end
   end

   initial begin
      rst_n     = 1'b0;
      priv_sup  = 1'b1;
      idle_sup  = 1'b1;
      ev_in     = '0;
      reg_addr  = '0;
      reg_wr    = 1'b0;
      reg_wdata = '0;
      repeat (3) @(negedge clk);

      // R1 reset state
      check_at(0, 32'h101, "R1 ctrl reset");
      check_at(1, 32'h0,   "R1 slot0 reset");
      check_at(2, 32'h0,   "R1 slot1 reset");
      check_at(3, 32'h0,   "R1 flags reset");

      @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R3: default setup ignores supervisor mode
      check_at(1, 32'h0, "R3 supervisor blocked by default");
      check_at(2, 32'h0, "R3 supervisor blocked slot1");

      // R2 + R4 + R9: both slots on cycles, user mode
      wr(2'd0, 32'hFFFF_F001);
      check_at(0, 32'h001, "R2 ctrl readback upper zero");
      run_ev(16'h0, 1'b0, 10);
      check_at(1, 32'd10, "R4 slot0 cycles");
      check_at(2, 32'd10, "R9 slot1 cycles in parallel");

      // R3: supervisor only
      idle_sup = 1'b0;
      wr(2'd0, 32'h002);
      run_ev(16'h0, 1'b1, 7);
      check_at(1, 32'd17, "R3 supervisor counted");
      run_ev(16'h0, 1'b0, 4);
      check_at(1, 32'd17, "R3 user blocked");
      check_at(2, 32'd17, "R3 user blocked slot1");

      // R5: reference on slot0, hit on slot1
      wr(2'd0, 32'h321);
      check_at(0, 32'h321, "R2 ctrl fields");
      wr(2'd1, 32'h0);
      wr(2'd2, 32'h0);
      run_ev(16'h000C, 1'b0, 6);
      check_at(1, 32'd6, "R5 slot0 code 2");
      check_at(2, 32'd6, "R5 slot1 code 3");
      run_ev(16'h0004, 1'b0, 3);
      check_at(1, 32'd9, "R9 slot0 alone");
      check_at(2, 32'd6, "R9 slot1 unchanged");

      // R6: codes not accepted
      wr(2'd0, 32'h231);
      run_ev(16'h000C, 1'b0, 5);
      check_at(1, 32'd9, "R6 code 3 on slot0");
      check_at(2, 32'd6, "R6 code 2 on slot1");
      wr(2'd0, 32'hCC1);
      run_ev(16'hFFFF, 1'b0, 4);
      check_at(1, 32'd9, "R6 code 12 slot0");
      check_at(2, 32'd6, "R6 code 12 slot1");

      // R5: stall levels held several cycles
      wr(2'd0, 32'h761);
      run_ev(16'h0040, 1'b0, 8);
      check_at(1, 32'd17, "R5 load stall level");
      run_ev(16'h0080, 1'b0, 2);
      check_at(2, 32'd8, "R5 fpu stall level");
      run_ev(16'h00C0, 1'b0, 3);
      check_at(1, 32'd20, "R9 simultaneous slot0");
      check_at(2, 32'd11, "R9 simultaneous slot1");

      // R8: wrap and sticky flag
      wr(2'd1, 32'hFFFF_FFFE);
      run_ev(16'h0040, 1'b0, 1);
      check_at(1, 32'hFFFF_FFFF, "R8 at top");
      check_at(3, 32'h0,         "R8 no flag before wrap");
      run_ev(16'h0040, 1'b0, 1);
      check_at(1, 32'h0, "R8 wrapped");
      check_at(3, 32'h1, "R8 flag set");
      run_ev(16'h0040, 1'b0, 1);
      check_at(1, 32'h1, "R8 counts after wrap");
      check_at(3, 32'h1, "R8 flag sticky");
      wr(2'd0, 32'h761);
      check_at(3, 32'h0, "R8 ctrl write clears");
      wr(2'd2, 32'hFFFF_FFFF);
      run_ev(16'h0080, 1'b0, 1);
      check_at(3, 32'h2, "R8 slot1 flag");

      // R7: write priority and pre-increment read
      idle_sup = 1'b1;
      wr(2'd0, 32'h601);
      @(negedge clk);
      priv_sup = 1'b0;
      push_check(1, 32'h1, "R7 read before edge");
      reg_wdata = 32'd100;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr   = 1'b0;
      priv_sup = 1'b1;
      push_check(1, 32'd100, "R7 write beats increment");
      push_check(2, 32'h0,   "R9 slot1 untouched by write");
      @(negedge clk);
      priv_sup = 1'b0;
      push_check(1, 32'd100, "R7 pre-increment value");
      @(negedge clk);
      priv_sup = 1'b1;
      push_check(1, 32'd101, "R4 one cycle counted");

      done = 1'b1;
      repeat (2) @(negedge clk);
      summary();
   end

endmodule